// File: doc/BRIEF.md
# Three-Stage Stalling Accumulator Core

This block is a small in-order processor. Its pipeline has three stages: fetch, execute and store. Fetch reads a 16-bit instruction word from an internal program memory. Execute decodes the word, reads the two 8-bit architectural registers (A and B) and computes the result. Store commits the result to a register or to the internal data memory. When there is no dependence, a new word enters fetch on every clock. While one instruction commits, the next one executes and the one after that is being fetched.

There are no forwarding paths. Suppose the instruction in execute reads a register that the instruction in store is about to write. Execute then holds its instruction and fetch holds its counter, and an empty slot (a no-op bubble) moves on into store. The producer commits at the end of that cycle, and the held instruction goes ahead on the next cycle. Instructions ahead of the stalled one keep moving; instructions behind it wait.

The program is written through a valid/ready port, and only while reset is held. Back-pressure: `prog_ready` is high exactly while `rst` is high. A word is taken on a rising edge only if both `prog_valid` and `prog_ready` are high. Any word offered while the core runs is dropped. Data memory and both registers can be read at any time on plain output pins.

Top module: `acc3_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), `reg_a`, `reg_b`, `stall` and `done` are all 0, and fetching starts at program address 0 once reset is released.
- R2: Instruction word layout:
  - bits [15:14] hold the opcode: 00 load-immediate, 01 copy, 10 add-immediate, 11 store.
  - bit 13 selects the destination register (0 = A, 1 = B).
  - bit 12 selects the source register (0 = A, 1 = B).
  - bits [11:0] hold the operand field. Load-immediate and add-immediate use its low 8 bits. Store uses its low 10 bits as the data-memory address.
- R3: Load-immediate sets dst to the immediate. Copy sets dst to src. Add-immediate sets dst to dst plus the immediate, modulo 256. Store writes src into data memory at the address. Registers change only when a register-writing instruction commits in the store stage.
- R4: A program of N instructions followed by a halt word raises `done` at rising edge N+2+S after reset is released, where S is the number of stall cycles from R5.
- R5: A stall happens when the instruction in execute reads a register that the instruction just before it writes:
  - copy reads src, add-immediate reads dst, store reads src.
  - the stall lasts exactly one cycle and `stall` is high during it.
  - the program counter holds and a bubble enters the store stage.
- R6: The program "load A with 40; copy A to B; add 20 to B; store B at 0x300" leaves 60 at data address 0x300, A = 40 and B = 60, with 3 stall cycles.
- R7: A copy word whose dst equals its src is a halt. Fetching stops, older instructions drain, and `done` rises. Words after the halt are never executed. `done` and the registers stay fixed until reset.
- R8: Program writes are accepted only while `rst` is high (`prog_ready` = 1). A write offered while running changes nothing that executes.
- R9: The first instruction's result appears on the register outputs after the third rising edge following reset release, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_valid | input | 1 | Program word offered |
| prog_ready | output | 1 | Program word can be taken (high during reset) |
| prog_addr | input | 6 | Program memory address |
| prog_word | input | 16 | Instruction word |
| peek_addr | input | 10 | Data memory read address |
| peek_data | output | 8 | Data memory contents at `peek_addr` |
| reg_a | output | 8 | Register A |
| reg_b | output | 8 | Register B |
| stall | output | 1 | Execute is held by a register dependence this cycle |
| done | output | 1 | Halt reached and pipeline drained |

## Verification
The hardest case to reach from the pins is a stall that lands right next to another event: a halt word, a wrapping add, or a chain of back-to-back dependences. Only certain adjacent pairs of instructions produce it. To cover these, the bench runs every ordered pair of the four opcodes, with every destination and source choice, between a register setup and a register dump. That gives 256 programs, and they include every pairwise hazard and every halt position. An arithmetic model in the bench gives the expected completion cycle, stall count, registers and memory for each program. Directed programs add the commit latency, a write attempted while running, and the reference program.

// File: rtl/acc3_pkg.sv
package acc3_pkg;
  localparam int WORD_W  = 16;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 12;
  localparam int OP_LSB  = 14;
  localparam int DST_BIT = 13;
  localparam int SRC_BIT = 12;

  typedef enum logic [1:0] {
    OP_LDI  = 2'b00,
    OP_COPY = 2'b01,
    OP_ADDI = 2'b10,
    OP_STR  = 2'b11
  } op_e;

  typedef struct packed {
    logic               valid;
    logic               reg_wr;
    logic               reg_sel;
    logic               mem_wr;
    logic [FIELD_W-1:0] addr;
    logic [DATA_W-1:0]  data;
  } commit_t;

  function automatic op_e op_of(input logic [WORD_W-1:0] w);
    return op_e'(w[OP_LSB +: 2]);
  endfunction

  function automatic logic is_halt(input logic [WORD_W-1:0] w);
    return (op_of(w) == OP_COPY) && (w[DST_BIT] == w[SRC_BIT]);
  endfunction

  function automatic logic reads_reg(input logic [WORD_W-1:0] w);
    return (op_of(w) != OP_LDI) && !is_halt(w);
  endfunction

  function automatic logic read_sel(input logic [WORD_W-1:0] w);
    return (op_of(w) == OP_ADDI) ? w[DST_BIT] : w[SRC_BIT];
  endfunction
endpackage

// File: rtl/acc3_fetch.sv
module acc3_fetch
  import acc3_pkg::*;
#(
  parameter int IAW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [IAW-1:0]    prog_addr,
  input  logic [WORD_W-1:0] prog_word,
  input  logic              advance,
  output logic [IAW-1:0]    pc,
  output logic [WORD_W-1:0] instr
);
  localparam int DEPTH = 1 << IAW;

  logic [WORD_W-1:0] imem [DEPTH];

  assign prog_ready = rst;

  always_ff @(posedge clk) begin
    if (prog_valid && prog_ready) imem[prog_addr] <= prog_word;
  end

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (advance) pc <= pc + 1'b1;
  end

  assign instr = imem[pc];
endmodule

// File: rtl/acc3_exec.sv
module acc3_exec
  import acc3_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] fetch_instr,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic              st_reg_wr,
  input  logic              st_reg_sel,
  output logic              fetch_en,
  output logic              stall,
  output logic              halted,
  output logic              ex_valid,
  output commit_t           issue
);
  logic [WORD_W-1:0]  ex_instr;
  logic               ex_halt;
  op_e                op;
  logic               dst_sel, src_sel;
  logic [FIELD_W-1:0] fld;
  logic [DATA_W-1:0]  imm, src_val, dst_val;

  always_comb begin
    op      = op_of(ex_instr);
    dst_sel = ex_instr[DST_BIT];
    src_sel = ex_instr[SRC_BIT];
    fld     = ex_instr[FIELD_W-1:0];
    imm     = DATA_W'(fld);
    src_val = src_sel ? reg_b : reg_a;
    dst_val = dst_sel ? reg_b : reg_a;
    ex_halt = ex_valid && is_halt(ex_instr);
    stall   = ex_valid && reads_reg(ex_instr) && st_reg_wr &&
              (st_reg_sel == read_sel(ex_instr));
    fetch_en = !halted && !ex_halt && !stall;
  end

  always_comb begin
    issue         = '0;
    issue.valid   = ex_valid && !stall && !ex_halt;
    issue.reg_wr  = (op != OP_STR);
    issue.mem_wr  = (op == OP_STR);
    issue.reg_sel = dst_sel;
    issue.addr    = fld;
    unique case (op)
      OP_LDI:  issue.data = imm;
      OP_COPY: issue.data = src_val;
      OP_ADDI: issue.data = dst_val + imm;
      OP_STR:  issue.data = src_val;
      default: issue.data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_instr <= '0;
      halted   <= 1'b0;
    end else begin
      if (!stall) begin
        ex_valid <= fetch_en;
        ex_instr <= fetch_instr;
      end
      if (ex_halt) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/acc3_store.sv
module acc3_store
  import acc3_pkg::*;
#(
  parameter int DAW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  commit_t           issue,
  input  logic [DAW-1:0]    peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic              st_valid,
  output logic              st_reg_wr,
  output logic              st_reg_sel
);
  localparam int DDEPTH = 1 << DAW;

  commit_t           st;
  logic [DATA_W-1:0] regs [2];
  logic [DATA_W-1:0] dmem [DDEPTH];
  logic [DAW-1:0]    wr_addr;

  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= issue;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs[0] <= '0;
      regs[1] <= '0;
    end else if (st.valid && st.reg_wr) begin
      regs[st.reg_sel] <= st.data;
    end
  end

  assign wr_addr = DAW'(st.addr);

  always_ff @(posedge clk) begin
    if (st.valid && st.mem_wr) dmem[wr_addr] <= st.data;
  end

  assign peek_data  = dmem[peek_addr];
  assign reg_a      = regs[0];
  assign reg_b      = regs[1];
  assign st_valid   = st.valid;
  assign st_reg_wr  = st.valid && st.reg_wr;
  assign st_reg_sel = st.reg_sel;
endmodule

// File: rtl/acc3_core.sv
module acc3_core
  import acc3_pkg::*;
#(
  parameter int IAW = 6,
  parameter int DAW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_valid,
  output logic              prog_ready,
  input  logic [IAW-1:0]    prog_addr,
  input  logic [WORD_W-1:0] prog_word,
  input  logic [DAW-1:0]    peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic              stall,
  output logic              done
);
  logic [IAW-1:0]    pc_w;
  logic [WORD_W-1:0] instr_w;
  logic              fetch_en_w, halted_w, ex_valid_w;
  logic              st_valid_w, st_reg_wr_w, st_reg_sel_w;
  commit_t           issue_w;

  acc3_fetch #(.IAW(IAW)) u_fetch (
    .clk(clk), .rst(rst),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_word(prog_word),
    .advance(fetch_en_w), .pc(pc_w), .instr(instr_w)
  );

  acc3_exec u_exec (
    .clk(clk), .rst(rst), .fetch_instr(instr_w),
    .reg_a(reg_a), .reg_b(reg_b),
    .st_reg_wr(st_reg_wr_w), .st_reg_sel(st_reg_sel_w),
    .fetch_en(fetch_en_w), .stall(stall), .halted(halted_w),
    .ex_valid(ex_valid_w), .issue(issue_w)
  );

  acc3_store #(.DAW(DAW)) u_store (
    .clk(clk), .rst(rst), .issue(issue_w),
    .peek_addr(peek_addr), .peek_data(peek_data),
    .reg_a(reg_a), .reg_b(reg_b),
    .st_valid(st_valid_w), .st_reg_wr(st_reg_wr_w), .st_reg_sel(st_reg_sel_w)
  );

  assign done = halted_w && !ex_valid_w && !st_valid_w;
endmodule

// File: rtl/acc3_core_chk.sv
module acc3_core_chk
  import acc3_pkg::*;
#(
  parameter int IAW = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              done,
  input logic              st_valid,
  input logic              st_reg_wr,
  input logic [IAW-1:0]    pc,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b
);
  assert_stall_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    stall |=> !st_valid);

  assert_stall_holds_pc_R5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (pc == $past(pc)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_no_fetch_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(pc));

  assert_regs_frozen_when_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(reg_a) && $stable(reg_b)));

  assert_regs_change_only_at_commit_R3: assert property (@(posedge clk) disable iff (rst)
    !st_reg_wr |=> ($stable(reg_a) && $stable(reg_b)));
endmodule

bind acc3_core acc3_core_chk #(.IAW(IAW)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .done(done),
  .st_valid(st_valid_w), .st_reg_wr(st_reg_wr_w), .pc(pc_w),
  .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/acc3_core_test.sv
`timescale 1ns/1ps
module acc3_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_valid = 1'b0;
  logic        prog_ready;
  logic [5:0]  prog_addr = '0;
  logic [15:0] prog_word = '0;
  logic [9:0]  peek_addr = '0;
  logic [7:0]  peek_data, reg_a, reg_b;
  logic        stall, done;

  int checks = 0;
  int bad = 0;

  logic [15:0] prog [16];
  int plen;
  int mem_model [1024];
  int st_list [16];
  int n_st;
  int trace_a [32];
  bit poke;
  logic [15:0] poke_word;

  always #2.5 clk = ~clk;

  acc3_core uut (
    .clk(clk), .rst(rst), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_word(prog_word), .peek_addr(peek_addr),
    .peek_data(peek_data), .reg_a(reg_a), .reg_b(reg_b),
    .stall(stall), .done(done)
  );

  function automatic logic [15:0] enc(input int op, input int d, input int s, input int f);
    return {op[1:0], d[0], s[0], f[11:0]};
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sequential model of the instruction set (R2, R3) and of the stall rule (R5).
  task automatic model(output int ea, output int eb, output int ecyc, output int estl);
    int a, b, n, s, val, rsel;
    bit prev_wr, prev_sel, rneed;
    a = 0; b = 0; n = 0; s = 0; prev_wr = 0; prev_sel = 0; n_st = 0;
    for (int i = 0; i < plen; i++) begin
      int op, d, sr, f, imm;
      op = int'(prog[i][15:14]); d = int'(prog[i][13]); sr = int'(prog[i][12]);
      f = int'(prog[i][11:0]); imm = f & 255;
      if (op == 1 && d == sr) break;
      rneed = (op != 0);
      rsel = (op == 2) ? d : sr;
      if (rneed && prev_wr && (rsel == int'(prev_sel))) s++;
      val = 0;
      case (op)
        0: val = imm;
        1: val = sr ? b : a;
        2: val = ((d ? b : a) + imm) & 255;
        default: begin
          mem_model[f & 1023] = sr ? b : a;
          st_list[n_st] = f & 1023;
          n_st++;
        end
      endcase
      if (op != 3) begin
        if (d != 0) b = val; else a = val;
        prev_wr = 1; prev_sel = d[0];
      end else begin
        prev_wr = 0;
      end
      n++;
    end
    ea = a; eb = b; ecyc = n + 2 + s; estl = s;
  endtask

  task automatic run_prog(input string tag);
    int ea, eb, ecyc, estl, cyc, stl, a_end, b_end;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < plen; i++) begin
      prog_valid = 1'b1; prog_addr = 6'(i); prog_word = prog[i];
      @(negedge clk);
    end
    prog_valid = 1'b0;
    chk_eq({"R1 reg_a in reset ", tag}, int'(reg_a), 0);
    chk_eq({"R1 reg_b in reset ", tag}, int'(reg_b), 0);
    chk_eq({"R1 done in reset ", tag}, int'(done), 0);
    chk_eq({"R1 stall in reset ", tag}, int'(stall), 0);
    chk_eq({"R8 ready in reset ", tag}, int'(prog_ready), 1);
    model(ea, eb, ecyc, estl);
    rst = 1'b0;
    if (poke) begin
      prog_valid = 1'b1; prog_addr = 6'd2; prog_word = poke_word;
    end
    cyc = 0; stl = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc < 32) trace_a[cyc] = int'(reg_a);
      if (stall) stl++;
      if (poke && cyc == 1) chk_eq({"R8 ready low while running ", tag}, int'(prog_ready), 0);
      if (cyc == 3) prog_valid = 1'b0;
    end
    prog_valid = 1'b0;
    if (cyc >= 200) chk_eq({"R4 watchdog ", tag}, cyc, ecyc);
    chk_eq({"R4 done cycle ", tag}, cyc, ecyc);
    chk_eq({"R5 stall cycles ", tag}, stl, estl);
    chk_eq({"R3 reg_a ", tag}, int'(reg_a), ea);
    chk_eq({"R3 reg_b ", tag}, int'(reg_b), eb);
    a_end = int'(reg_a); b_end = int'(reg_b);
    for (int i = 0; i < n_st; i++) begin
      peek_addr = 10'(st_list[i]);
      #1;
      chk_eq({"R3 data memory ", tag}, int'(peek_data), mem_model[st_list[i]]);
    end
    repeat (3) @(negedge clk);
    chk_eq({"R7 done stays high ", tag}, int'(done), 1);
    chk_eq({"R7 reg_a frozen ", tag}, int'(reg_a), a_end);
    chk_eq({"R7 reg_b frozen ", tag}, int'(reg_b), b_end);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    poke = 0; poke_word = '0;
    repeat (2) @(negedge clk);

    // R9: first result appears after the third edge, not the second.
    prog[0] = enc(0, 0, 0, 12'h05A); prog[1] = enc(1, 0, 0, 0); plen = 2;
    run_prog("latency");
    chk_eq("R9 reg_a after edge 2", trace_a[2], 0);
    chk_eq("R9 reg_a after edge 3", trace_a[3], 90);

    // R6: reference program with three dependent pairs.
    prog[0] = enc(0, 0, 0, 40); prog[1] = enc(1, 1, 0, 0);
    prog[2] = enc(2, 1, 0, 20); prog[3] = enc(3, 0, 1, 12'h300);
    prog[4] = enc(1, 1, 1, 0);  plen = 5;
    run_prog("example R6");
    peek_addr = 10'h300; #1;
    chk_eq("R6 memory 0x300", int'(peek_data), 60);
    chk_eq("R6 reg_b", int'(reg_b), 60);

    // R3 wrap: 200 + 100 = 44 modulo 256.
    prog[0] = enc(0, 0, 0, 200); prog[1] = enc(2, 0, 0, 100);
    prog[2] = enc(1, 0, 0, 0); plen = 3;
    run_prog("wrap");
    chk_eq("R3 add wraps", int'(reg_a), 44);

    // R7: words after halt never run.
    prog[0] = enc(0, 0, 0, 1); prog[1] = enc(1, 1, 1, 0);
    prog[2] = enc(0, 0, 0, 9); prog[3] = enc(1, 0, 0, 0); plen = 4;
    run_prog("after halt R7");
    chk_eq("R7 word after halt skipped", int'(reg_a), 1);

    // R8: a write offered while running is dropped.
    prog[0] = enc(0, 0, 0, 5); prog[1] = enc(0, 1, 0, 6);
    prog[2] = enc(0, 0, 0, 7); prog[3] = enc(1, 0, 0, 0); plen = 4;
    poke = 1; poke_word = enc(0, 0, 0, 99);
    run_prog("run write R8");
    poke = 0;
    chk_eq("R8 running write ignored", int'(reg_a), 7);

    // R4: independent chain, no stalls.
    for (int i = 0; i < 12; i++) prog[i] = enc(0, i & 1, 0, i * 17 + 3);
    prog[12] = enc(1, 0, 0, 0); plen = 13;
    run_prog("chain R4");

    // Sweep every ordered pair of opcodes and register selects (R2, R3, R4, R5, R7).
    for (int k = 0; k < 256; k++) begin
      prog[0] = enc(0, 0, 0, (k * 29 + 3) & 255);
      prog[1] = enc(0, 1, 0, (k * 53 + 250) & 255);
      prog[2] = enc((k >> 6) & 3, (k >> 5) & 1, (k >> 4) & 1, 12'h100 | (k & 255));
      prog[3] = enc((k >> 2) & 3, (k >> 1) & 1, k & 1, 12'h200 | ((k * 13 + 5) & 255));
      prog[4] = enc(3, 0, 0, 12'h3F0);
      prog[5] = enc(3, 0, 1, 12'h3F1);
      prog[6] = enc(1, 0, 0, 0);
      plen = 7;
      run_prog($sformatf("sweep %0d", k));
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule